// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a free-running up-counter, `CNT_W` bits wide (16 by default), that advances on a clock-enable tick from a selectable prescaler running off the system clock. Software-style register writes reach two 8-bit registers. The control register holds the prescale select and the rollover interrupt enable. The status register holds the rollover flag. The live count is a plain output, so capture channels elsewhere can latch it at any time.

The prescale select is a set-once field. It takes a value only during a short window after reset, and only the first write inside that window counts. After that it is frozen until the next reset. The rollover flag is sticky and is cleared by writing a one to it. The interrupt request is the flag gated by its enable. The reset input is expected to be released synchronously to `clk` by the reset tree outside this block.

Top module: `tmr_freerun`

## Requirements
- R1: While reset is held, and on the first sample after its release, the count, the control readback, the status readback and the interrupt request are all zero.
- R2: On a clock edge with a prescaler tick, the count advances by exactly one, wrapping from all ones to zero. On an edge without a tick it holds.
- R3: Control bits [1:0] select the division: 00 gives divide-by-1, 01 gives 4, 10 gives 8 and 11 gives 16. A 4-bit divider is cleared by reset and steps every clock. Counting edges from 0 at the first edge after reset, the count steps on edge k when k mod N equals N-1.
- R4: A control write (address 0) changes the prescale select only if it occurs on one of the first `WIN` (64) edges after reset.
- R5: Only the first control write inside that window sets the prescale select. Every later control write leaves bits [1:0] unchanged.
- R6: Control bit 7 is the rollover interrupt enable and takes the written value on every control write. Control bits 6..2 always read zero.
- R7: Status bit 7 (address 1) becomes 1 on the edge where the count wraps from all ones to zero. Status bits 6..0 always read zero.
- R8: A status write with bit 7 set clears the flag. A status write with bit 7 clear leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag ends set.
- R9: The interrupt request equals the flag AND the enable at all times, and stays high until one of the two is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| wr_en | input | 1 | Register write strobe, one edge per write |
| wr_addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| count_o | output | CNT_W | Live counter value |
| ctrl_rd_o | output | 8 | Control register readback |
| stat_rd_o | output | 8 | Status register readback |
| irq_o | output | 1 | Rollover interrupt request |

## Verification
The assertions assume that `rst_n` already meets the clock's recovery timing, and that the write inputs are settled around each rising edge and change only between edges. The bench drives every input on the falling edge and samples on the next falling edge, so each write lands on exactly one known edge. In the long rollover run, random control data has its prescale bits forced to zero, so the window rule cannot pick a slow divisor and push the wrap out of reach. The window edges 63 and 64 are written by directed cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned PS_W    = 2;
  localparam int unsigned DIV_W   = 4;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned OVF_BIT = 7;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_STAT = 1'b1
  } reg_addr_e;

  function automatic int unsigned ps_divisor(input logic [PS_W-1:0] sel);
    case (sel)
      2'b00:   ps_divisor = 1;
      2'b01:   ps_divisor = 4;
      2'b10:   ps_divisor = 8;
      default: ps_divisor = 16;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] keep;

  always_comb begin
    div_d  = div_q + 1'b1;
    keep   = DIV_W'(ps_divisor(ps_sel) - 1);
    tick_o = ((div_q & keep) == keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_DIV_ONE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_sel == 2'b00) |-> tick_o); // R3
  AST_TICK_AFTER_TICK_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ps_sel != 2'b00 && $stable(ps_sel)) |=> !tick_o); // R3
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = tick ? cnt_q + 1'b1 : cnt_q;
    wrap_o = tick && (cnt_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned WIN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_addr_e       wr_addr,
  input  logic [PS_W-1:0] wd_ps,
  input  logic            wd_en,
  input  logic            wd_clr,
  input  logic            wrap,
  output logic [PS_W-1:0] ps_o,
  output logic            en_o,
  output logic            flag_o
);
  localparam int unsigned WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] win_q, win_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic             lock_q, lock_d;
  logic             en_q, en_d;
  logic             flag_q, flag_d;
  logic             in_win, ctrl_wr, ps_wr, clr_req;

  always_comb begin
    in_win  = (win_q < WIN_W'(WIN));
    win_d   = in_win ? win_q + 1'b1 : win_q;
    ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    ps_wr   = ctrl_wr && in_win && !lock_q;
    clr_req = wr_en && (wr_addr == ADDR_STAT) && wd_clr;
    ps_d    = ps_wr ? wd_ps : ps_q;
    lock_d  = lock_q || ps_wr;
    en_d    = ctrl_wr ? wd_en : en_q;
    flag_d  = wrap || (flag_q && !clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      ps_q   <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      ps_q   <= ps_d;
      lock_q <= lock_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign ps_o   = ps_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;

  AST_PS_FROZEN_OUT_OF_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> $stable(ps_q)); // R4
  AST_PS_FROZEN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ps_q)); // R5
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wrap) |=> !flag_q); // R8
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       ctrl_rd_o,
  output logic [7:0]       stat_rd_o,
  output logic             irq_o
);
  logic [PS_W-1:0] ps;
  logic            tick, wrap, en, flag;
  logic            unused_wd;

  assign unused_wd = ^wr_data;

  tmr_prescale i_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .ps_sel (ps),
    .tick_o (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) i_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt_o  (count_o),
    .wrap_o (wrap)
  );

  tmr_regs #(.WIN(WIN)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (reg_addr_e'(wr_addr)),
    .wd_ps   (wr_data[PS_W-1:0]),
    .wd_en   (wr_data[EN_BIT]),
    .wd_clr  (wr_data[OVF_BIT]),
    .wrap    (wrap),
    .ps_o    (ps),
    .en_o    (en),
    .flag_o  (flag)
  );

  always_comb begin
    ctrl_rd_o             = '0;
    ctrl_rd_o[PS_W-1:0]   = ps;
    ctrl_rd_o[EN_BIT]     = en;
    stat_rd_o             = '0;
    stat_rd_o[OVF_BIT]    = flag;
    irq_o                 = flag && en;
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_rd_o[OVF_BIT]); // R9
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_en) |=> irq_o); // R9
endmodule

// File: tb/test_tmr_freerun.sv
module test_tmr_freerun;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] count;
  logic [7:0]  ctrl_rd, stat_rd;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model state
  int unsigned m_k;
  logic [15:0] m_cnt;
  logic [1:0]  m_ps;
  logic        m_lock, m_en, m_flag;

  always #4 clk = ~clk;

  tmr_freerun i_tmr_freerun (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_o   (count),
    .ctrl_rd_o (ctrl_rd),
    .stat_rd_o (stat_rd),
    .irq_o     (irq)
  );

  function automatic int unsigned divn(input logic [1:0] s);
    case (s)
      2'b00: divn = 1;
      2'b01: divn = 4;
      2'b10: divn = 8;
      default: divn = 16;
    endcase
  endfunction

  function automatic logic [7:0] exp_ctrl();
    exp_ctrl = {m_en, 5'b0, m_ps};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R3 count", 32'(count), 32'(m_cnt));
    chk("R4/R5/R6 ctrl", 32'(ctrl_rd), 32'(exp_ctrl()));
    chk("R7/R8 stat", 32'(stat_rd), 32'({m_flag, 7'b0}));
    chk("R9 irq", 32'(irq), 32'(m_flag & m_en));
  endtask

  task automatic model_step(input logic we, input logic a, input logic [7:0] d);
    int unsigned n;
    logic tick, wrap;
    n    = divn(m_ps);
    tick = ((m_k % n) == n - 1);
    wrap = tick && (m_cnt == 16'hFFFF);
    if (tick) m_cnt = m_cnt + 16'd1;
    if (we && a == 1'b0) begin
      m_en = d[7];
      if (m_k < 64 && !m_lock) begin
        m_ps   = d[1:0];
        m_lock = 1'b1;
      end
    end
    m_flag = wrap || (m_flag && !(we && a == 1'b1 && d[7]));
    m_k++;
  endtask

  // called at a falling edge; applies one edge and checks at the next fall
  task automatic cyc(input logic we, input logic a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    model_step(we, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", 32'(count), 32'h0);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    m_k = 0; m_cnt = '0; m_ps = '0; m_lock = 1'b0; m_en = 1'b0; m_flag = 1'b0;
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 ctrl", 32'(ctrl_rd), 32'h0);
    chk("R1 stat", 32'(stat_rd), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic rand_cyc(input bit safe_ps);
    logic we, a;
    logic [7:0] d;
    we = ($urandom % 6) == 0;
    a  = 1'($urandom);
    d  = 8'($urandom);
    if (safe_ps && a == 1'b0) d = d & 8'hFC;
    cyc(we, a, d);
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h1A2B3C4D);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;

    // R3/R4: divide-by-8 set early, R5: later window write ignored
    do_reset();
    cyc(0, 0, 8'h00); cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h02);                  // R3 select 10 -> divide by 8
    repeat (5) cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h83);                  // R5 ps stays 10, R6 enable set
    chk("R5 ps kept after second write", 32'(ctrl_rd[1:0]), 32'h2);
    chk("R6 enable written", 32'(ctrl_rd[7]), 32'h1);
    while (m_k < 70) cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h01);                  // R4 outside window
    chk("R4 ps frozen after window", 32'(ctrl_rd[1:0]), 32'h2);
    repeat (300) rand_cyc(1'b0);

    // R3: divide-by-4, second in-window write ignored
    do_reset();
    cyc(1, 0, 8'h01);
    repeat (4) cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h7F);                  // R5, R6 bits 6..2 read zero
    chk("R6 reserved bits zero", 32'(ctrl_rd), 32'h01);
    repeat (200) rand_cyc(1'b0);

    // R4: last window edge (63) accepted -> divide by 16
    do_reset();
    while (m_k < 63) cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h03);
    chk("R4 write on edge 63 accepted", 32'(ctrl_rd[1:0]), 32'h3);
    repeat (100) cyc(0, 0, 8'h00);

    // R4: edge 64 rejected
    do_reset();
    while (m_k < 64) cyc(0, 0, 8'h00);
    cyc(1, 0, 8'h02);
    chk("R4 write on edge 64 rejected", 32'(ctrl_rd[1:0]), 32'h0);
    repeat (50) cyc(0, 0, 8'h00);

    // R7/R8/R9: full rollover at divide-by-1
    do_reset();
    while (m_cnt < 16'hFFF0) rand_cyc(1'b1);
    cyc(0, 1, 8'h80);                  // write strobe low: no effect
    cyc(1, 1, 8'h80);                  // clear any earlier flag
    cyc(1, 0, 8'h80);                  // enable
    while (m_cnt != 16'hFFFF) cyc(0, 0, 8'h00);
    cyc(1, 1, 8'h80);                  // R8 wrap and clear same edge: set wins
    chk("R7 count wrapped", 32'(count), 32'h0);
    chk("R8 set beats clear", 32'(stat_rd), 32'h80);
    chk("R9 irq on wrap", 32'(irq), 32'h1);
    repeat (3) cyc(0, 0, 8'h00);
    cyc(1, 1, 8'h7F);                  // R8 zero in bit 7 keeps flag
    chk("R8 write zero keeps flag", 32'(stat_rd), 32'h80);
    cyc(1, 0, 8'h00);
    chk("R9 irq drops with enable", 32'(irq), 32'h0);
    cyc(1, 0, 8'h80);
    chk("R9 irq back with enable", 32'(irq), 32'h1);
    cyc(1, 1, 8'h80);
    chk("R8 write one clears", 32'(stat_rd), 32'h0);
    chk("R9 irq after clear", 32'(irq), 32'h0);
    repeat (20) cyc(0, 0, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule